// File: doc/BRIEF.md
# DMA Channel Enable and Halt Sequencer

This block is the control logic that sits beside one DMA channel. It holds the channel's configuration bits (enable, halt, bus lock) and its control word (protection attributes, terminal-count interrupt enable). It decides when the channel accepts peripheral requests, and it runs the orderly shutdown of the channel. The bus-master datapath, address generation and linked-list fetching sit outside the block. They reach it only as simple status strobes: a beat in progress, a list item finished, a transfer complete, an error, and FIFO push and pop pulses.

There are two ways to stop the channel. In a plain disable, software clears the enable bit. The channel lets any bus beat already in flight finish, then drops enable and flushes the FIFO, so the buffered data is lost. In a lossless shutdown, software first sets halt. New peripheral requests are then refused while the FIFO keeps draining, and an active flag stays high until the FIFO is empty. Software waits for that flag to clear before it clears enable. The channel also turns itself off when a list item finishes, when the transfer completes, or when an error occurs.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, en_o, halt_o, active_o, bus_lock, tc_irq, err_flag, req_ack and fifo_flush are 0, and cfg_rdata reads 0.
- R2: A configuration write with bit 0 set, made while the channel is idle, raises en_o and cfg_rdata bit 0 on the next cycle.
- R3: A configuration write with bit 0 clear keeps en_o high for as long as beat_busy is high. en_o falls in the cycle after beat_busy is sampled low.
- R4: When en_o falls, fifo_flush pulses high for exactly that one cycle, and active_o is 0 on the cycle after.
- R5: While the channel runs, a pulse on xfer_done, lli_last_done or xfer_err disables the channel in the same graceful way as a software disable.
- R6: Configuration bit 2 is halt and appears on halt_o. While halt is set, req_ack stays 0, and FIFO pops still drain the count.
- R7: Configuration bit 17 (read-only) and active_o are 1 while the FIFO count is nonzero. The count rises on fifo_push and falls on fifo_pop, saturating at DEPTH and at 0.
- R8: lli_load replaces the control word with lli_ctl and leaves every configuration bit unchanged, even when lli_ctl has bits 0 to 2 set.
- R9: Control bits 30:28 drive bus_prot, and configuration bit 1 drives bus_lock. tc_irq can be 1 only while control bit 31 is 1.
- R10: A write with bit 0 set is ignored while the channel is stopping or flushing. en_o stays 0 until a write made in the idle state.
- R11: The terminal-count flag (set by xfer_done or lli_last_done while running with the interrupt enabled) and err_flag (set by xfer_err while enabled) stay high until a clr_stb pulse.
- R12: req_ack equals periph_req while the channel is running and not halted, and it is 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| lli_load | input | 1 | A new list item's control word is being loaded |
| lli_ctl | input | 32 | Control word carried by the new list item |
| clr_stb | input | 1 | Clears the sticky terminal-count and error flags |
| periph_req | input | 1 | Peripheral DMA request |
| beat_busy | input | 1 | A bus beat is in flight |
| fifo_push | input | 1 | One entry written into the channel FIFO |
| fifo_pop | input | 1 | One entry drained from the channel FIFO |
| lli_last_done | input | 1 | Last list item finished |
| xfer_done | input | 1 | Transfer complete |
| xfer_err | input | 1 | Channel error |
| cfg_rdata | output | 32 | Configuration readback (enable, lock, halt, active) |
| en_o | output | 1 | Channel enabled |
| halt_o | output | 1 | Halt bit |
| active_o | output | 1 | FIFO holds data |
| req_ack | output | 1 | Peripheral request accepted |
| fifo_flush | output | 1 | Discard FIFO contents |
| bus_prot | output | 3 | Bus protection attributes |
| bus_lock | output | 1 | Bus lock attribute |
| tc_irq | output | 1 | Terminal-count interrupt |
| err_flag | output | 1 | Sticky channel error |

## Verification
A sequencer stuck in the wrong state shows up within one cycle at en_o and req_ack. It either accepts a request it should refuse, or it drops enable while beat_busy is still high. A wrong FIFO count shows on active_o and cfg_rdata bit 17 on the cycle after the push or pop that caused it. A missing flush leaves active_o high on the cycle after en_o falls. Corrupted configuration or control state appears at once on halt_o, bus_lock, bus_prot and tc_irq.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int REG_W        = 32;
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_LOCK_BIT = 1;
    localparam int CFG_HALT_BIT = 2;
    localparam int CFG_ACT_BIT  = 17;
    localparam int CTL_IRQ_BIT  = 31;
    localparam int PROT_W       = 3;
    localparam int CTL_PROT_LSB = 28;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_STOP  = 2'd2,
        ST_FLUSH = 2'd3
    } chan_st_e;

    typedef struct packed {
        logic halt;
        logic lock;
    } cfg_t;

    typedef struct packed {
        logic              irq_en;
        logic [PROT_W-1:0] prot;
    } ctl_t;

    function automatic ctl_t ctl_decode(input logic [REG_W-1:0] w);
        ctl_t c;
        c.irq_en = w[CTL_IRQ_BIT];
        c.prot   = w[CTL_PROT_LSB +: PROT_W];
        return c;
    endfunction

    function automatic cfg_t cfg_decode(input logic [REG_W-1:0] w);
        cfg_t c;
        c.halt = w[CFG_HALT_BIT];
        c.lock = w[CFG_LOCK_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_pack(input logic en, input logic act,
                                                  input cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[CFG_EN_BIT]   = en;
        w[CFG_LOCK_BIT] = c.lock;
        w[CFG_HALT_BIT] = c.halt;
        w[CFG_ACT_BIT]  = act;
        return w;
    endfunction

endpackage

// File: rtl/chan_cfg_regs.sv
module chan_cfg_regs
    import dmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] ctl_wdata,
    input  logic             lli_load,
    input  logic [REG_W-1:0] lli_ctl,
    input  logic             tc_evt,
    input  logic             err_evt,
    input  logic             clr_stb,
    output cfg_t             cfg_q,
    output ctl_t             ctl_q,
    output logic             tc_flag,
    output logic             err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            ctl_q   <= '0;
            tc_flag <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (cfg_we)
                cfg_q <= cfg_decode(cfg_wdata);
            if (ctl_we)
                ctl_q <= ctl_decode(ctl_wdata);
            else if (lli_load)
                ctl_q <= ctl_decode(lli_ctl);
            if (tc_evt && ctl_q.irq_en)
                tc_flag <= 1'b1;
            else if (clr_stb)
                tc_flag <= 1'b0;
            if (err_evt)
                err_q <= 1'b1;
            else if (clr_stb)
                err_q <= 1'b0;
        end
    end

endmodule

// File: rtl/chan_fifo_track.sv
module chan_fifo_track #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  logic flush,
    output logic active
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cnt_q <= '0;
        end else if (push && !pop && cnt_q != FULL) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (pop && !push && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/chan_seq.sv
module chan_seq
    import dmac_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_we,
    input  logic     en_wr,
    input  logic     beat_busy,
    input  logic     auto_stop,
    output chan_st_e state,
    output logic     en,
    output logic     flush
);

    chan_st_e nxt;
    logic     stop_req;

    assign stop_req = (cfg_we && !en_wr) || auto_stop;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (cfg_we && en_wr) nxt = ST_RUN;
            ST_RUN:   if (stop_req) nxt = beat_busy ? ST_STOP : ST_FLUSH;
            ST_STOP:  if (!beat_busy) nxt = ST_FLUSH;
            ST_FLUSH: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign en    = (state == ST_RUN) || (state == ST_STOP);
    assign flush = (state == ST_FLUSH);

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dmac_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [REG_W-1:0]     cfg_wdata,
    input  logic                 ctl_we,
    input  logic [REG_W-1:0]     ctl_wdata,
    input  logic                 lli_load,
    input  logic [REG_W-1:0]     lli_ctl,
    input  logic                 clr_stb,
    input  logic                 periph_req,
    input  logic                 beat_busy,
    input  logic                 fifo_push,
    input  logic                 fifo_pop,
    input  logic                 lli_last_done,
    input  logic                 xfer_done,
    input  logic                 xfer_err,
    output logic [REG_W-1:0]     cfg_rdata,
    output logic                 en_o,
    output logic                 halt_o,
    output logic                 active_o,
    output logic                 req_ack,
    output logic                 fifo_flush,
    output logic [PROT_W-1:0]    bus_prot,
    output logic                 bus_lock,
    output logic                 tc_irq,
    output logic                 err_flag
);

    cfg_t     cfg_q;
    ctl_t     ctl_q;
    chan_st_e seq_state;
    logic     tc_flag;
    logic     running;
    logic     done_evt;

    assign running  = (seq_state == ST_RUN);
    assign done_evt = xfer_done || lli_last_done;

    chan_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .lli_load  (lli_load),
        .lli_ctl   (lli_ctl),
        .tc_evt    (done_evt && running),
        .err_evt   (xfer_err && en_o),
        .clr_stb   (clr_stb),
        .cfg_q     (cfg_q),
        .ctl_q     (ctl_q),
        .tc_flag   (tc_flag),
        .err_q     (err_flag)
    );

    chan_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .en_wr     (cfg_wdata[CFG_EN_BIT]),
        .beat_busy (beat_busy),
        .auto_stop (done_evt || xfer_err),
        .state     (seq_state),
        .en        (en_o),
        .flush     (fifo_flush)
    );

    chan_fifo_track #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .push   (fifo_push),
        .pop    (fifo_pop),
        .flush  (fifo_flush),
        .active (active_o)
    );

    assign halt_o    = cfg_q.halt;
    assign bus_lock  = cfg_q.lock;
    assign bus_prot  = ctl_q.prot;
    assign req_ack   = periph_req && running && !cfg_q.halt;
    assign tc_irq    = tc_flag && ctl_q.irq_en;
    assign cfg_rdata = cfg_pack(en_o, active_o, cfg_q);

endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk
    import dmac_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     beat_busy,
    input logic     en_o,
    input logic     halt_o,
    input logic     active_o,
    input logic     req_ack,
    input logic     fifo_flush,
    input logic     tc_irq,
    input logic     err_flag,
    input logic     clr_stb,
    input logic     lli_load,
    input logic     cfg_we,
    input logic     bus_lock,
    input ctl_t     ctl_q,
    input chan_st_e seq_state
);

    // R3
    en_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(en_o) |-> !$past(beat_busy));

    // R4
    flush_on_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(en_o) |-> fifo_flush);

    // R4
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |=> !active_o && !fifo_flush);

    // R6
    halt_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        halt_o |-> !req_ack);

    // R8
    lli_keeps_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (lli_load && !cfg_we) |=> $stable(halt_o) && $stable(bus_lock));

    // R9
    tc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        tc_irq |-> ctl_q.irq_en);

    // R10
    reenable_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en_o) |-> $past(seq_state) == ST_IDLE);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clr_stb) |=> err_flag);

    // R12
    ack_running_chk: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> seq_state == ST_RUN);

endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .beat_busy  (beat_busy),
    .en_o       (en_o),
    .halt_o     (halt_o),
    .active_o   (active_o),
    .req_ack    (req_ack),
    .fifo_flush (fifo_flush),
    .tc_irq     (tc_irq),
    .err_flag   (err_flag),
    .clr_stb    (clr_stb),
    .lli_load   (lli_load),
    .cfg_we     (cfg_we),
    .bus_lock   (bus_lock),
    .ctl_q      (ctl_q),
    .seq_state  (seq_state)
);

// File: tb/dma_chan_ctrl_tb_top.sv
module dma_chan_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 0, ctl_we = 0, lli_load = 0, clr_stb = 0;
    logic [31:0] cfg_wdata = '0, ctl_wdata = '0, lli_ctl = '0;
    logic        periph_req = 0, beat_busy = 0, fifo_push = 0, fifo_pop = 0;
    logic        lli_last_done = 0, xfer_done = 0, xfer_err = 0;
    logic [31:0] cfg_rdata;
    logic        en_o, halt_o, active_o, req_ack, fifo_flush, bus_lock, tc_irq, err_flag;
    logic [2:0]  bus_prot;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dma_chan_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .lli_load(lli_load), .lli_ctl(lli_ctl),
        .clr_stb(clr_stb), .periph_req(periph_req), .beat_busy(beat_busy),
        .fifo_push(fifo_push), .fifo_pop(fifo_pop), .lli_last_done(lli_last_done),
        .xfer_done(xfer_done), .xfer_err(xfer_err), .cfg_rdata(cfg_rdata),
        .en_o(en_o), .halt_o(halt_o), .active_o(active_o), .req_ack(req_ack),
        .fifo_flush(fifo_flush), .bus_prot(bus_prot), .bus_lock(bus_lock),
        .tc_irq(tc_irq), .err_flag(err_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [31:0] d);
        cfg_we = 1; cfg_wdata = d; tick(); cfg_we = 0; cfg_wdata = '0;
    endtask

    task automatic wr_ctl(input logic [31:0] d);
        ctl_we = 1; ctl_wdata = d; tick(); ctl_we = 0;
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin fifo_push = 1; tick(); end
        fifo_push = 0;
    endtask

    task automatic go_idle();
        tick(3);
    endtask

    task automatic t_reset();
        chk("R1 en", en_o, 0);
        chk("R1 cfg_rdata", cfg_rdata, 0);
        chk("R1 flags", {halt_o, active_o, bus_lock, tc_irq, err_flag, req_ack, fifo_flush}, 0);
    endtask

    task automatic t_enable();
        wr_cfg(32'h1);
        chk("R2 en_o", en_o, 1);
        chk("R2 rdata bit0", cfg_rdata[0], 1);
        wr_cfg(32'h1);
        chk("R2 rewrite keeps enabled", en_o, 1);
    endtask

    task automatic t_accept();
        periph_req = 1; #1;
        chk("R12 ack running", req_ack, 1);
        periph_req = 0; #1;
        chk("R12 no req no ack", req_ack, 0);
    endtask

    task automatic t_fifo_count();
        push_n(3);
        chk("R7 active", active_o, 1);
        chk("R7 rdata bit17", cfg_rdata[17], 1);
        fifo_pop = 1; tick(2); fifo_pop = 0;
        chk("R7 still one left", active_o, 1);
        fifo_pop = 1; tick(); fifo_pop = 0;
        chk("R7 empty", {active_o, cfg_rdata[17]}, 0);
        fifo_pop = 1; tick(); fifo_pop = 0;
        push_n(1);
        chk("R7 no underflow", active_o, 1);
        fifo_pop = 1; tick(); fifo_pop = 0;
        push_n(10);
        fifo_pop = 1; tick(8); fifo_pop = 0;
        chk("R7 saturate at depth", active_o, 0);
    endtask

    task automatic t_graceful_disable();
        push_n(3);
        beat_busy = 1;
        wr_cfg(32'h0);
        chk("R3 en held during beat", en_o, 1);
        periph_req = 1; #1;
        chk("R12 no ack while stopping", req_ack, 0);
        periph_req = 0;
        tick(3);
        chk("R3 en held while busy", en_o, 1);
        beat_busy = 0; tick();
        chk("R3 en drops after beat", en_o, 0);
        chk("R4 flush pulse", fifo_flush, 1);
        tick();
        chk("R4 fifo discarded", active_o, 0);
        chk("R4 flush one cycle", fifo_flush, 0);
        chk("R4 rdata after", cfg_rdata, 0);
    endtask

    task automatic t_halt();
        wr_cfg(32'h1);
        push_n(2);
        wr_cfg(32'h5);
        chk("R6 halt_o", halt_o, 1);
        chk("R6 rdata halt", cfg_rdata[2], 1);
        periph_req = 1; #1;
        chk("R6 request refused", req_ack, 0);
        fifo_pop = 1; tick(); fifo_pop = 0;
        chk("R6 still draining", active_o, 1);
        fifo_pop = 1; tick(); fifo_pop = 0;
        chk("R6 drained", active_o, 0);
        chk("R6 still enabled", en_o, 1);
        wr_cfg(32'h4);
        chk("R6 disable after drain", en_o, 0);
        periph_req = 0;
        wr_cfg(32'h0);
        go_idle();
    endtask

    task automatic t_auto(input int which);
        wr_cfg(32'h1);
        case (which)
            0: xfer_done = 1;
            1: lli_last_done = 1;
            default: xfer_err = 1;
        endcase
        tick();
        xfer_done = 0; lli_last_done = 0; xfer_err = 0;
        chk($sformatf("R5 auto disable cause %0d", which), en_o, 0);
        chk("R5 flush", fifo_flush, 1);
        go_idle();
    endtask

    task automatic t_irq_sticky();
        wr_ctl(32'h0);
        t_auto(0);
        chk("R9 no irq when disabled in ctl", tc_irq, 0);
        wr_ctl(32'h8000_0000);
        chk("R9 no stale tc", tc_irq, 0);
        t_auto(1);
        chk("R11 tc set", tc_irq, 1);
        tick(4);
        chk("R11 tc sticky", tc_irq, 1);
        wr_ctl(32'h0);
        chk("R9 irq gated by bit31", tc_irq, 0);
        wr_ctl(32'h8000_0000);
        clr_stb = 1; tick(); clr_stb = 0;
        chk("R11 tc cleared", tc_irq, 0);
        t_auto(2);
        chk("R11 err set", err_flag, 1);
        tick(4);
        chk("R11 err sticky", err_flag, 1);
        clr_stb = 1; tick(); clr_stb = 0;
        chk("R11 err cleared", err_flag, 0);
    endtask

    task automatic t_lli_attr();
        wr_cfg(32'h6);
        wr_ctl(32'h5000_0000);
        chk("R9 bus_prot", bus_prot, 3'b101);
        chk("R9 bus_lock", bus_lock, 1);
        lli_load = 1; lli_ctl = 32'h2000_0007; tick(); lli_load = 0;
        chk("R8 prot reloaded", bus_prot, 3'b010);
        chk("R8 cfg unchanged", cfg_rdata, 32'h6);
        chk("R8 halt kept", halt_o, 1);
        wr_cfg(32'h0);
        wr_ctl(32'h0);
        chk("R9 lock cleared", bus_lock, 0);
    endtask

    task automatic t_reenable();
        wr_cfg(32'h1);
        beat_busy = 1;
        wr_cfg(32'h0);
        wr_cfg(32'h1);
        chk("R10 write while stopping ignored", en_o, 1);
        beat_busy = 0; tick();
        chk("R10 dropped", en_o, 0);
        wr_cfg(32'h1);
        chk("R10 write during flush ignored", en_o, 0);
        tick();
        chk("R10 still off", en_o, 0);
        wr_cfg(32'h1);
        chk("R10 idle write enables", en_o, 1);
        wr_cfg(32'h0);
        go_idle();
    endtask

    initial begin
        tick(3);
        rst = 0;
        t_reset();
        t_enable();
        t_accept();
        t_fifo_count();
        t_graceful_disable();
        t_halt();
        t_auto(0);
        t_irq_sticky();
        t_lli_attr();
        t_reenable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule